// File: doc/BRIEF.md
# Destructive-Read Double-Column Hit Encoder

This block holds the hit state of every pixel in one double column of a pixel matrix and drains it, one pixel address per transfer. A strobe copies the hit lines of both columns into a bank of state bits. From then on the block offers, on a valid/ready output stream, the address of the lowest-numbered pixel that still holds a hit. Each accepted transfer clears the state bit of the pixel it reported, so the next hit appears on the following cycle. Pixels that were not hit are never reported, which gives zero suppression for free. A matrix places one such encoder on each double column, and a shared periphery collects the words.

Stream rules: `out_valid` is high whenever at least one state bit is set, and `out_addr` is then the lowest set index. A transfer happens on a rising clock edge where both `out_valid` and `out_ready` are high. While `out_ready` is low the word is held unchanged and nothing is cleared. `out_valid` never drops without a transfer, except through reset. A strobe is only taken while the bank is empty, so the set being drained never changes in the middle of a readout.

Top module: `hit_drain_encoder`

## Requirements
- R1: Pixel address `{row, col}`: bit 0 holds the column (0 for `col0_hit`, 1 for `col1_hit`) and bits [9:1] hold the row, 0 to 511.
- R2: A strobe sampled high while `out_valid` is low loads both columns of hit lines into the state bank; if any line was high, `out_valid` is high from that same edge onward.
- R3: Only pixels whose hit line was high at the accepted strobe are reported, each exactly once.
- R4: Addresses leave in strictly ascending order, so row r column 0 comes before row r column 1, which comes before row r+1.
- R5: A transfer clears the reported pixel's state on that edge, and the next address (or `out_valid` low) is presented after the same edge, so one address can be drained per cycle.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_addr` keeps its value.
- R7: A strobe while `out_valid` is high is ignored: the pending set does not change.
- R8: Reset clears every state bit, drives `out_valid` low and `empty` high.
- R9: `empty` is `out_valid` inverted and delayed by one clock: it rises on the edge after `out_valid` falls and falls on the edge after `out_valid` rises.
- R10: A strobe with all hit lines low leaves `out_valid` low and `empty` high.
- R11: The hit lines are sampled only at an accepted strobe; changing them at other times has no effect on the reported addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| col0_hit | input | 512 | Hit lines of the first column, one per row |
| col1_hit | input | 512 | Hit lines of the second column, one per row |
| strobe | input | 1 | Latch the hit lines into the state bank (only when empty) |
| out_ready | input | 1 | Read request: consumer takes the current address |
| out_valid | output | 1 | At least one hit pixel remains; `out_addr` is meaningful |
| out_addr | output | 10 | Address of the lowest-numbered remaining hit pixel |
| empty | output | 1 | Delayed indication that the bank has drained |

## Verification
On every cycle the assertions check that `out_valid` agrees with the state bank, that the presented address points at a set bit, and that a transfer clears exactly that bit. They also check that the word and the bank hold under back-pressure, that successive addresses increase, and that `empty` trails `out_valid` by one edge. Only the bench's scenarios can show the complete reported set against a known hit pattern: zero suppression, the row/column interleaving, and the rejection of a strobe or of hit line changes during a readout. The bench also covers full occupancy and reset in the middle of a drain.

// File: rtl/hde_pkg.sv
package hde_pkg;
  // Rows served by one encoder; the bank holds two columns of this many.
  localparam int DEF_ROWS  = 512;
  // Width of one first-level search group in the priority tree.
  localparam int DEF_GROUP = 32;
endpackage

// File: rtl/hde_state_bank.sv
module hde_state_bank #(
  parameter int N  = 1024,
  localparam int AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [N-1:0]  hit_i,
  input  logic          clr_i,
  input  logic [AW-1:0] clr_addr_i,
  output logic [N-1:0]  state_q,
  output logic [N-1:0]  state_d
);
  for (genvar i = 0; i < N; i++) begin : g_pix
    localparam logic [AW-1:0] IDX = AW'(i);
    always_comb begin
      if (load_i)                          state_d[i] = hit_i[i];
      else if (clr_i && clr_addr_i == IDX) state_d[i] = 1'b0;
      else                                 state_d[i] = state_q[i];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q[i] <= 1'b0;
      else        state_q[i] <= state_d[i];
    end
  end

  // Loading and clearing are never requested together by the top.
  p_load_clr_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(load_i && clr_i));
endmodule

// File: rtl/hde_low_find.sv
module hde_low_find #(
  parameter int W  = 32,
  localparam int IW = $clog2(W)
) (
  input  logic [W-1:0]  bits_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (bits_i[i]) idx_o = IW'(i);
    end
    any_o = |bits_i;
  end
endmodule

// File: rtl/hde_prio_tree.sv
module hde_prio_tree #(
  parameter int N     = 1024,
  parameter int GROUP = 32,
  localparam int NG   = N / GROUP,
  localparam int GW   = $clog2(GROUP),
  localparam int SW   = $clog2(NG),
  localparam int AW   = $clog2(N)
) (
  input  logic [N-1:0]  vec_i,
  output logic          any_o,
  output logic [AW-1:0] addr_o
);
  logic [NG-1:0] grp_any;
  logic [GW-1:0] grp_idx [NG];
  logic [SW-1:0] grp_sel;

  for (genvar g = 0; g < NG; g++) begin : g_grp
    hde_low_find #(.W(GROUP)) u_find (
      .bits_i(vec_i[g*GROUP +: GROUP]),
      .any_o (grp_any[g]),
      .idx_o (grp_idx[g])
    );
  end

  hde_low_find #(.W(NG)) u_sel (
    .bits_i(grp_any),
    .any_o (any_o),
    .idx_o (grp_sel)
  );

  assign addr_o = {grp_sel, grp_idx[grp_sel]};
endmodule

// File: rtl/hit_drain_encoder.sv
module hit_drain_encoder #(
  parameter int ROWS  = hde_pkg::DEF_ROWS,
  parameter int GROUP = hde_pkg::DEF_GROUP,
  localparam int PIX  = 2 * ROWS,
  localparam int AW   = $clog2(PIX)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [ROWS-1:0] col0_hit,
  input  logic [ROWS-1:0] col1_hit,
  input  logic            strobe,
  input  logic            out_ready,
  output logic            out_valid,
  output logic [AW-1:0]   out_addr,
  output logic            empty
);
  logic [PIX-1:0] hit_vec, state_q, state_d;
  logic           load, fire, nxt_any;
  logic [AW-1:0]  nxt_addr;

  // Interleave the two columns: pixel index = 2*row + column.
  for (genvar r = 0; r < ROWS; r++) begin : g_map
    assign hit_vec[2*r]   = col0_hit[r];
    assign hit_vec[2*r+1] = col1_hit[r];
  end

  assign fire = out_valid && out_ready;
  assign load = strobe && !out_valid;

  hde_state_bank #(.N(PIX)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (load),
    .hit_i     (hit_vec),
    .clr_i     (fire),
    .clr_addr_i(out_addr),
    .state_q   (state_q),
    .state_d   (state_d)
  );

  // Search the next-state so the registered head matches the bank.
  hde_prio_tree #(.N(PIX), .GROUP(GROUP)) u_tree (
    .vec_i (state_d),
    .any_o (nxt_any),
    .addr_o(nxt_addr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_addr  <= '0;
      empty     <= 1'b1;
    end else begin
      out_valid <= nxt_any;
      out_addr  <= nxt_addr;
      empty     <= !out_valid;
    end
  end

  p_valid_matches_bank_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == (|state_q));
  p_addr_is_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> state_q[out_addr]);
  p_fire_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !state_q[$past(out_addr)]);
  p_ascending_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(fire)) |-> (out_addr > $past(out_addr)));
  p_hold_backpressure_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_addr)));
  p_bank_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> $stable(state_q));
  p_empty_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_valid) |=> empty);
  p_empty_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |=> !empty);
endmodule

// File: tb/sim_hit_drain_encoder.sv
module sim_hit_drain_encoder;
  localparam int ROWS = 512;
  localparam int PIX  = 2 * ROWS;
  localparam int AW   = 10;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [ROWS-1:0] col0_hit = '0, col1_hit = '0;
  logic            strobe = 1'b0, out_ready = 1'b0;
  logic            out_valid, empty;
  logic [AW-1:0]   out_addr;

  int checks = 0, failures = 0;
  bit done = 1'b0;
  logic [PIX-1:0] exp_set;

  always #2.5 clk = ~clk;

  hit_drain_encoder u0 (
    .clk(clk), .rst_n(rst_n), .col0_hit(col0_hit), .col1_hit(col1_hit),
    .strobe(strobe), .out_ready(out_ready), .out_valid(out_valid),
    .out_addr(out_addr), .empty(empty)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive_set(input logic [PIX-1:0] s);
    for (int r = 0; r < ROWS; r++) begin
      col0_hit[r] = s[2*r];
      col1_hit[r] = s[2*r+1];
    end
  endtask

  // Strobe exp_set in; returns at the negedge after the loading edge.
  task automatic load_set();
    @(negedge clk);
    drive_set(exp_set);
    strobe = 1'b1;
    @(negedge clk);
    strobe = 1'b0;
    drive_set('0);
  endtask

  // Drain with ready held high; expects one address per cycle, ascending.
  task automatic drain(input string req);
    out_ready = 1'b1;
    for (int p = 0; p < PIX; p++) begin
      if (exp_set[p]) begin
        check(out_valid == 1'b1, req, int'(out_valid), 1);
        check(int'(out_addr) == p, req, int'(out_addr), p);
        @(negedge clk);
      end
    end
    out_ready = 1'b0;
    check(out_valid == 1'b0, {req, " R5 drained"}, int'(out_valid), 0);
    exp_set = '0;
  endtask

  task automatic t_reset();
    check(out_valid == 1'b0, "R8 reset valid", int'(out_valid), 0);
    check(empty == 1'b1, "R8 reset empty", int'(empty), 1);
  endtask

  task automatic t_single();
    exp_set = '0;
    exp_set[11] = 1'b1;                  // R1: row 5, column 1
    load_set();
    check(out_valid == 1'b1, "R2 valid after strobe", int'(out_valid), 1);
    check(empty == 1'b1, "R9 empty lags rise", int'(empty), 1);
    @(negedge clk);
    check(empty == 1'b0, "R9 empty falls", int'(empty), 0);
    check(int'(out_addr) == 11, "R1 row5 col1", int'(out_addr), 11);
    drain("R1");
    check(empty == 1'b0, "R9 empty lags fall", int'(empty), 0);
    @(negedge clk);
    check(empty == 1'b1, "R9 empty rises", int'(empty), 1);
  endtask

  task automatic t_sparse();
    exp_set = '0;
    exp_set[0] = 1'b1; exp_set[1] = 1'b1; exp_set[6] = 1'b1;
    exp_set[512] = 1'b1; exp_set[1023] = 1'b1; exp_set[77] = 1'b1;
    load_set();
    drain("R3 R4 sparse");
  endtask

  task automatic t_dense();
    exp_set = '0;
    for (int p = 20; p < 40; p++) exp_set[p] = 1'b1;
    load_set();
    drain("R5 dense");
  endtask

  task automatic t_backpressure();
    exp_set = '0;
    exp_set[300] = 1'b1; exp_set[301] = 1'b1; exp_set[900] = 1'b1;
    load_set();
    out_ready = 1'b0;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      check(out_valid == 1'b1, "R6 hold valid", int'(out_valid), 1);
      check(int'(out_addr) == 300, "R6 hold addr", int'(out_addr), 300);
    end
    drain("R6 after hold");
  endtask

  task automatic t_busy_strobe();
    logic [PIX-1:0] other;
    exp_set = '0;
    exp_set[4] = 1'b1; exp_set[9] = 1'b1; exp_set[40] = 1'b1;
    load_set();
    out_ready = 1'b1;
    @(negedge clk);                      // address 4 taken
    out_ready = 1'b0;
    exp_set[4] = 1'b0;
    other = '0;
    other[2] = 1'b1; other[500] = 1'b1;
    drive_set(other);
    strobe = 1'b1;
    @(negedge clk);
    strobe = 1'b0;
    check(int'(out_addr) == 9, "R7 busy strobe ignored", int'(out_addr), 9);
    drive_set(~other);                   // R11: lines toggle mid-readout
    @(negedge clk);
    drive_set('0);
    drain("R7 R11 original set");
  endtask

  task automatic t_zero_strobe();
    exp_set = '0;
    load_set();
    for (int k = 0; k < 3; k++) begin
      check(out_valid == 1'b0, "R10 no valid", int'(out_valid), 0);
      check(empty == 1'b1, "R10 stays empty", int'(empty), 1);
      @(negedge clk);
    end
  endtask

  task automatic t_reset_mid();
    exp_set = '0;
    exp_set[100] = 1'b1; exp_set[200] = 1'b1;
    load_set();
    rst_n = 1'b0;
    #1;
    check(out_valid == 1'b0, "R8 reset mid valid", int'(out_valid), 0);
    check(empty == 1'b1, "R8 reset mid empty", int'(empty), 1);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R8 state cleared", int'(out_valid), 0);
    exp_set = '0;
  endtask

  task automatic t_full();
    exp_set = '1;
    load_set();
    drain("R3 R4 full");
  endtask

  initial begin
    #1000000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_single();
    t_sparse();
    t_dense();
    t_backpressure();
    t_busy_strobe();
    t_zero_strobe();
    t_reset_mid();
    t_full();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule